// File: doc/BRIEF.md
# Transmit Frame Finisher: Zero Padding and FCS Append

This block is a byte-stream stage in the transmit path of an Ethernet MAC. Frame bytes arrive on a valid/ready handshake. A start marker flags the first byte of a frame and an end marker flags the last. Per-frame option flags and a speed select are captured together with the start byte.

On the line side the block drives a transmit enable and the transmit data. If the frame asks for padding, the block appends zero bytes to short frames. If any of four option bits is set, it appends a 32-bit frame check sequence. In 10/100 mode each byte goes out as two 4-bit beats. In gigabit mode one byte goes out per cycle.

When a frame ends, a one-cycle done pulse reports it, together with a flag that tells a normal end from an aborted one. A frame is aborted either by an explicit abort request or by the source failing to supply the next byte in time. Preamble generation and inter-frame gap timing are handled elsewhere.

Top module: `tx_pad_fcs_stage`

## Requirements
- R1: The FCS is appended when at least one of `frm_pad_en`, `frm_fcs_en`, `glb_pad_fcs`, `glb_fcs` is set. When all four are clear, the line carries exactly the data bytes.
- R2: When `frm_pad_en` is set and the frame has fewer than 60 data bytes, zero bytes are sent after the data until 60 bytes have gone out, and only then the FCS. Frames of 60 or more bytes, and frames without `frm_pad_en`, are never padded. `glb_pad_fcs` does not cause padding.
- R3: `tx_en` stays high without a gap from the first byte until the last byte has finished. It is low in the next cycle. In the first cycle with `tx_en` low, `done_pulse` is high for one cycle with `done_aborted` = 0.
- R4: In 10/100 mode (`spd_gig` = 0) each byte occupies two cycles. The low nibble goes out first on `tx_data[3:0]` and the high nibble second. `tx_data[7:4]` is 0 while `tx_en` is high.
- R5: In gigabit mode (`spd_gig` = 1) one byte appears on `tx_data[7:0]` per cycle, in stream order.
- R6: The FCS is a CRC-32 computed over the data and pad bytes. It uses the reflected polynomial 0xEDB88320 with an initial value of all ones, processing each byte bit 0 first. The register is complemented and sent least-significant byte first.
- R7: When `abort_req` is sampled high while a frame is on the line, `tx_en` is low in the next cycle, no further byte (and no FCS) is sent, and `done_pulse` fires in that cycle with `done_aborted` = 1. Any input bytes of that frame not yet taken are accepted and dropped, up to and including the one marked last.
- R8: If the line needs the next data byte and `in_valid` is low, the frame ends exactly as in R7.
- R9: While idle, `in_ready` is 1. Bytes without the start marker are accepted and dropped with no activity on the line. `tx_en` rises in the cycle after the start byte is accepted.
- R10: Speed select and all four option bits are sampled with the start byte. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Frame byte from upstream |
| in_valid | input | 1 | `in_data` holds a byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is taken at this edge when valid |
| frm_pad_en | input | 1 | Per-frame: pad to minimum and add FCS |
| frm_fcs_en | input | 1 | Per-frame: add FCS |
| glb_pad_fcs | input | 1 | Global pad/FCS bit (enables FCS) |
| glb_fcs | input | 1 | Global FCS bit |
| spd_gig | input | 1 | 1 = byte-wide gigabit, 0 = nibble 10/100 |
| abort_req | input | 1 | End the current frame at once |
| tx_data | output | 8 | Line data (nibble on [3:0] in 10/100) |
| tx_en | output | 1 | Transmit enable |
| done_pulse | output | 1 | One-cycle end-of-frame pulse |
| done_aborted | output | 1 | Qualifies `done_pulse`: frame was cut short |

## Verification
Three situations are hard to reach from the ports because they depend on where the frame is on the line when the event lands.

The first is an abort that arrives while padding or FCS bytes are going out. At that point no input byte of the frame is left, so no drain phase should follow. The bench times the abort from the count of line samples it has already captured. This places the request at a chosen byte: inside the data, inside the FCS, or in the first cycle of a nibble pair.

The second is underrun. The bench withholds `in_valid` after a few accepted bytes, then delivers the rest of the frame to show that it is dropped.

The third is the pad boundary. Sweeps over lengths just below, at and above 60 bytes, with all sixteen flag combinations and both speeds, reach it. Each frame flips the speed and flags after its start byte.

// File: rtl/tx_finish_pkg.sv
package tx_finish_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_TAIL,
    ST_DRAIN
  } fin_state_e;

  // One byte through the reflected CRC-32 register, bit 0 of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ d[k];
      r  = {1'b0, r[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/txf_crc_acc.sv
module txf_crc_acc
  import tx_finish_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] fcs_word
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= '1;
    else if (start) crc_q <= crc32_step('1, din);
    else if (upd)   crc_q <= crc32_step(crc_q, din);
  end

  assign fcs_word = ~crc_q;

endmodule

// File: rtl/txf_lane_ser.sv
module txf_lane_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              stop,
  output logic              slot_free,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_en
);
  localparam int NIB_W = BYTE_W / 2;

  logic [BYTE_W-1:0] byte_q;
  logic              act_q;
  logic              nib_q;
  logic              last_beat;

  assign last_beat = gig | nib_q;
  assign slot_free = !act_q | last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      act_q  <= 1'b0;
      nib_q  <= 1'b0;
    end else if (stop) begin
      act_q <= 1'b0;
      nib_q <= 1'b0;
    end else if (ld) begin
      byte_q <= ld_byte;
      act_q  <= 1'b1;
      nib_q  <= 1'b0;
    end else if (act_q) begin
      nib_q <= gig ? 1'b0 : ~nib_q;
    end
  end

  always_comb begin
    if (gig) begin
      tx_data = byte_q;
    end else begin
      tx_data = '0;
      tx_data[NIB_W-1:0] = nib_q ? byte_q[BYTE_W-1:NIB_W] : byte_q[NIB_W-1:0];
    end
  end

  assign tx_en = act_q;

  // R3: once a byte has finished on the line, the controller must supply the
  // next byte or close the frame; it may never leave the line unfed.
  assert_line_fed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && slot_free) |-> (ld || stop));

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import tx_finish_pkg::*;
#(
  parameter int MIN_PAYLOAD = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic        in_last,
  output logic        in_ready,
  input  logic        frm_pad_en,
  input  logic        frm_fcs_en,
  input  logic        glb_pad_fcs,
  input  logic        glb_fcs,
  input  logic        spd_gig,
  input  logic        abort_req,
  input  logic        slot_free,
  input  logic [31:0] fcs_word,
  output logic        ld,
  output logic [7:0]  ld_byte,
  output logic        stop,
  output logic        crc_start,
  output logic        crc_upd,
  output logic [7:0]  crc_din,
  output logic        gig_q,
  output logic        done_pulse,
  output logic        done_aborted
);
  localparam int CW = $clog2(MIN_PAYLOAD + 1);
  localparam logic [CW-1:0] MINC = CW'(MIN_PAYLOAD);

  fin_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [1:0]    fi_q, fi_d;
  logic          pad_q, pad_d, fcs_q, fcs_d, gig_d;
  logic          src_q, src_d, done_q, done_d, dab_q, dab_d;
  logic          frame_live, fcs_any;

  function automatic fin_state_e after_data(input logic last, input logic [CW-1:0] n,
                                            input logic pad, input logic fcs);
    if (!last)                 return ST_DATA;
    else if (pad && n < MINC)  return ST_PAD;
    else if (fcs)              return ST_FCS;
    else                       return ST_TAIL;
  endfunction

  assign frame_live = (st_q == ST_DATA) || (st_q == ST_PAD) ||
                      (st_q == ST_FCS)  || (st_q == ST_TAIL);
  assign fcs_any    = frm_pad_en | frm_fcs_en | glb_pad_fcs | glb_fcs;
  assign cnt_inc    = (cnt_q == MINC) ? cnt_q : cnt_q + CW'(1);

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  fi_d = fi_q;
    pad_d = pad_q; fcs_d = fcs_q; gig_d = gig_q; src_d = src_q;
    done_d = 1'b0; dab_d = 1'b0;
    in_ready = 1'b0; ld = 1'b0; ld_byte = '0; stop = 1'b0;
    crc_start = 1'b0; crc_upd = 1'b0; crc_din = in_data;
    if (frame_live && abort_req) begin
      stop = 1'b1; done_d = 1'b1; dab_d = 1'b1;
      st_d = src_q ? ST_IDLE : ST_DRAIN;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          in_ready = 1'b1;
          if (in_valid && in_first) begin
            ld = 1'b1; ld_byte = in_data; crc_start = 1'b1;
            pad_d = frm_pad_en; fcs_d = fcs_any; gig_d = spd_gig;
            cnt_d = CW'(1); fi_d = '0; src_d = in_last;
            st_d = after_data(in_last, CW'(1), frm_pad_en, fcs_any);
          end
        end
        ST_DATA: begin
          if (slot_free) begin
            if (in_valid) begin
              in_ready = 1'b1; ld = 1'b1; ld_byte = in_data; crc_upd = 1'b1;
              cnt_d = cnt_inc; src_d = in_last;
              st_d = after_data(in_last, cnt_inc, pad_q, fcs_q);
            end else begin
              stop = 1'b1; done_d = 1'b1; dab_d = 1'b1; st_d = ST_DRAIN;
            end
          end
        end
        ST_PAD: begin
          if (slot_free) begin
            ld = 1'b1; ld_byte = '0; crc_upd = 1'b1; crc_din = '0; cnt_d = cnt_inc;
            if (cnt_inc == MINC) st_d = fcs_q ? ST_FCS : ST_TAIL;
          end
        end
        ST_FCS: begin
          if (slot_free) begin
            ld = 1'b1; ld_byte = fcs_word[{fi_q, 3'b000} +: 8]; fi_d = fi_q + 2'd1;
            if (fi_q == 2'd3) st_d = ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (slot_free) begin
            stop = 1'b1; done_d = 1'b1; st_d = ST_IDLE;
          end
        end
        ST_DRAIN: begin
          in_ready = 1'b1;
          if (in_valid && in_last) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; fi_q <= '0;
      pad_q <= 1'b0; fcs_q <= 1'b0; gig_q <= 1'b0; src_q <= 1'b0;
      done_q <= 1'b0; dab_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; fi_q <= fi_d;
      pad_q <= pad_d; fcs_q <= fcs_d; gig_q <= gig_d; src_q <= src_d;
      done_q <= done_d; dab_q <= dab_d;
    end
  end

  assign done_pulse   = done_q;
  assign done_aborted = dab_q;

  // R2: a padded frame reaches its checksum or its close only at the minimum length.
  assert_pad_reached_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FCS) || (st_q == ST_TAIL)) |-> (!pad_q || cnt_q == MINC));

  // R7: an abort during a live frame is reported as aborted one cycle later.
  assert_abort_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_live && abort_req) |=> (done_q && dab_q));

endmodule

// File: rtl/tx_pad_fcs_stage.sv
module tx_pad_fcs_stage #(
  parameter int BYTE_W    = 8,
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              frm_pad_en,
  input  logic              frm_fcs_en,
  input  logic              glb_pad_fcs,
  input  logic              glb_fcs,
  input  logic              spd_gig,
  input  logic              abort_req,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_en,
  output logic              done_pulse,
  output logic              done_aborted
);
  localparam int MIN_PAYLOAD = MIN_FRAME - FCS_BYTES;

  logic              slot_free, ld, stop, crc_start, crc_upd, gig_q;
  logic [7:0]        ld_byte, crc_din;
  logic [31:0]       fcs_word;

  txf_ctrl #(.MIN_PAYLOAD(MIN_PAYLOAD)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready),
    .frm_pad_en(frm_pad_en), .frm_fcs_en(frm_fcs_en),
    .glb_pad_fcs(glb_pad_fcs), .glb_fcs(glb_fcs),
    .spd_gig(spd_gig), .abort_req(abort_req),
    .slot_free(slot_free), .fcs_word(fcs_word),
    .ld(ld), .ld_byte(ld_byte), .stop(stop),
    .crc_start(crc_start), .crc_upd(crc_upd), .crc_din(crc_din),
    .gig_q(gig_q), .done_pulse(done_pulse), .done_aborted(done_aborted)
  );

  txf_crc_acc crc_i (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .upd(crc_upd),
    .din(crc_din), .fcs_word(fcs_word)
  );

  txf_lane_ser #(.BYTE_W(BYTE_W)) lane_i (
    .clk(clk), .rst_n(rst_n), .gig(gig_q), .ld(ld), .ld_byte(ld_byte),
    .stop(stop), .slot_free(slot_free), .tx_data(tx_data), .tx_en(tx_en)
  );

  // R7: a requested abort takes the line down in the next cycle.
  assert_abort_en_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && abort_req) |=> !tx_en);

  // R3: every falling edge of transmit enable comes with the done pulse.
  assert_done_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> done_pulse);

  // R3: the done pulse never overlaps an active line.
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !tx_en);

  // R4: no input byte is taken while the current byte is still mid-way on the line.
  assert_ready_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !slot_free) |-> !in_ready);

endmodule

// File: tb/tx_pad_fcs_stage_tb.sv
module tx_pad_fcs_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic       frm_pad_en = 1'b0, frm_fcs_en = 1'b0, glb_pad_fcs = 1'b0, glb_fcs = 1'b0;
  logic       spd_gig = 1'b0, abort_req = 1'b0;
  logic       in_ready, tx_en, done_pulse, done_aborted;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  tx_pad_fcs_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
    .frm_pad_en(frm_pad_en), .frm_fcs_en(frm_fcs_en),
    .glb_pad_fcs(glb_pad_fcs), .glb_fcs(glb_fcs),
    .spd_gig(spd_gig), .abort_req(abort_req),
    .tx_data(tx_data), .tx_en(tx_en),
    .done_pulse(done_pulse), .done_aborted(done_aborted)
  );

  // Line monitor
  logic [7:0] cap [0:1023];
  int  cap_n = 0, rises = 0, dones = 0;
  bit  prev_en = 1'b0, dn_ab = 1'b0, dn_fell = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (!prev_en) rises++;
        cap[cap_n % 1024] = tx_data;
        cap_n++;
      end
      if (done_pulse) begin
        dones++;
        dn_ab   = done_aborted;
        dn_fell = prev_en && !tx_en;
      end
      prev_en = tx_en;
    end
  end

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] ref_crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic drive_frame(input int len, input int seed, input bit flip, input int gap_after);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, i);
      in_first = (i == 0); in_last = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1;
      if (i == 0 && flip) begin
        spd_gig = ~spd_gig; frm_pad_en = ~frm_pad_en; frm_fcs_en = ~frm_fcs_en;
        glb_pad_fcs = ~glb_pad_fcs; glb_fcs = ~glb_fcs;
      end
      if (i + 1 == gap_after) begin
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_frame(input int len, input int seed, input bit pp, input bit pf,
                           input bit gp, input bit gf, input bit gig);
    logic [7:0]  expb [0:127];
    logic [7:0]  got;
    logic [31:0] c;
    int exp_n, base, rbase, dbase, n_got, mis;
    bit upper_ok;
    @(negedge clk);
    spd_gig = gig; frm_pad_en = pp; frm_fcs_en = pf; glb_pad_fcs = gp; glb_fcs = gf;
    base = cap_n; rbase = rises; dbase = dones;
    drive_frame(len, seed, 1'b1, -1);
    while (dones == dbase) @(negedge clk);
    @(negedge clk);
    // expected line content
    exp_n = 0;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin expb[exp_n] = pat(seed, i); exp_n++; end
    if (pp) while (exp_n < 60) begin expb[exp_n] = 8'h00; exp_n++; end
    for (int i = 0; i < exp_n; i++) c = ref_crc_byte(c, expb[i]);
    c = ~c;
    if (pp | pf | gp | gf) for (int k = 0; k < 4; k++) begin expb[exp_n] = c[8*k +: 8]; exp_n++; end
    n_got = gig ? (cap_n - base) : (cap_n - base) / 2;
    upper_ok = 1'b1;
    if (!gig) begin
      for (int k = base; k < cap_n; k++) if (cap[k % 1024][7:4] != 4'h0) upper_ok = 1'b0;
      chk(((cap_n - base) % 2) == 0, "R4 nibble pairs", cap_n - base, 2 * exp_n);
      chk(upper_ok, "R4 upper nibble zero", 0, 0);
    end
    chk(n_got == exp_n, "R1 R2 R10 length", n_got, exp_n);
    mis = -1;
    for (int i = 0; i < exp_n && i < n_got; i++) begin
      got = gig ? cap[(base + i) % 1024]
                : {cap[(base + 2 * i + 1) % 1024][3:0], cap[(base + 2 * i) % 1024][3:0]};
      if (mis < 0 && got != expb[i]) mis = i;
    end
    if (gig) chk(mis < 0, "R5 R6 byte content", mis, -1);
    else     chk(mis < 0, "R4 R6 nibble content", mis, -1);
    chk(rises - rbase == 1 && dn_fell && !dn_ab && dones - dbase == 1,
        "R3 enable and done", {rises - rbase, dn_fell, dn_ab}, {1, 1'b1, 1'b0});
  endtask

  int lens [6] = '{1, 2, 59, 60, 61, 75};
  int base0, rb0, db0;

  initial begin
    begin : crc_selftest
      logic [31:0] c;
      string s = "123456789";
      c = 32'hFFFFFFFF;
      foreach (s[i]) c = ref_crc_byte(c, s[i]);
      if (~c != 32'hCBF43926) $display("bench CRC model mismatch %0h", ~c);
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!tx_en && !done_pulse && in_ready, "R3 R9 reset state", {tx_en, done_pulse, in_ready}, 3'b001);

    // R9: stray bytes while idle are taken and dropped
    base0 = cap_n; rb0 = rises;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_first = 1'b0; in_last = (i == 2); in_data = 8'h5A;
      #1 chk(in_ready, "R9 idle ready", in_ready, 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (6) @(negedge clk);
    chk(cap_n == base0 && rises == rb0, "R9 stray bytes dropped", cap_n - base0, 0);

    // R9: enable rises the cycle after the start byte is taken
    @(negedge clk);
    spd_gig = 1'b1; frm_pad_en = 1'b0; frm_fcs_en = 1'b0; glb_pad_fcs = 1'b0; glb_fcs = 1'b0;
    in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_data = 8'hC3;
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(tx_en && tx_data == 8'hC3, "R9 start latency", {tx_en, tx_data}, {1'b1, 8'hC3});
    repeat (4) @(negedge clk);

    // sweeps: lengths x 16 flag sets x both speeds (R1 R2 R4 R5 R6 R10)
    for (int sp = 0; sp < 2; sp++)
      for (int li = 0; li < 6; li++)
        for (int f = 0; f < 16; f++)
          run_frame(lens[li], li * 16 + f + sp, f[0], f[1], f[2], f[3], sp[0]);

    // R7: abort during nibble-mode data, frame padded with FCS
    @(negedge clk);
    spd_gig = 1'b0; frm_pad_en = 1'b1; frm_fcs_en = 1'b0; glb_pad_fcs = 1'b0; glb_fcs = 1'b0;
    base0 = cap_n; rb0 = rises; db0 = dones;
    fork
      drive_frame(20, 7, 1'b0, -1);
      begin
        wait (cap_n >= base0 + 5);
        #2 abort_req = 1'b1;
        @(posedge clk); #1 abort_req = 1'b0;
        @(negedge clk); #1;
        chk(!tx_en && done_pulse && done_aborted, "R7 abort mid data",
            {tx_en, done_pulse, done_aborted}, 3'b011);
        chk(cap_n == base0 + 5, "R7 no further beats", cap_n - base0, 5);
      end
    join
    repeat (8) @(negedge clk);
    chk(rises == rb0 + 1 && dones == db0 + 1 && cap_n == base0 + 5, "R7 rest of frame dropped",
        cap_n - base0, 5);

    // R7: abort during FCS in gigabit mode, no drain afterwards
    @(negedge clk);
    spd_gig = 1'b1; frm_pad_en = 1'b0; frm_fcs_en = 1'b1;
    base0 = cap_n; db0 = dones;
    fork
      drive_frame(10, 9, 1'b0, -1);
      begin
        wait (cap_n >= base0 + 11);
        #2 abort_req = 1'b1;
        @(posedge clk); #1 abort_req = 1'b0;
        @(negedge clk); #1;
        chk(!tx_en && done_pulse && done_aborted, "R7 abort in FCS",
            {tx_en, done_pulse, done_aborted}, 3'b011);
      end
    join
    repeat (4) @(negedge clk);
    chk(cap_n == base0 + 11 && dones == db0 + 1, "R7 FCS cut short", cap_n - base0, 11);
    #1 chk(in_ready, "R7 idle after FCS abort", in_ready, 1);

    // R8: underrun after three bytes in gigabit mode
    base0 = cap_n; rb0 = rises; db0 = dones;
    drive_frame(10, 11, 1'b0, 3);
    repeat (6) @(negedge clk);
    chk(dones == db0 + 1 && dn_ab && !dn_fell == 1'b0, "R8 underrun reported aborted",
        {dones - db0, dn_ab}, {1, 1'b1});
    chk(cap_n == base0 + 3 && rises == rb0 + 1, "R8 remainder dropped", cap_n - base0, 3);

    // after everything, a clean frame still passes
    run_frame(12, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule